// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC, directly behind the start-of-frame delimiter detector. It looks at the first six bytes of each frame, which form the 48-bit destination address, and decides whether the frame is wanted. Three matching rules run in parallel. The first compares the address with the programmed station address. The second recognises the all-ones broadcast address. The third hashes a group address through CRC-32 into a 64-bit filter table. A promiscuous control accepts everything, and a broadcast-refusal control blocks the broadcast rule while leaving group hashing active.

The verdict appears as a one-cycle strobe in the cycle after the sixth address byte is taken. With the strobe come an accept flag and three flags that tell which rule matched. A frame that ends before its sixth byte produces no strobe. Downstream storage logic drops such a frame, or any frame whose strobe carries accept low.

Top module: `rxaf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_valid`, `dec_accept`, `hit_phys`, `hit_bcast` and `hit_mcast` are all 0.
- R2: Byte i of the address (i = 0 is the first byte taken after `rx_sof`) is compared with `cfg_station[8*i+7:8*i]`. `hit_phys` is 1 exactly when all six bytes are equal to their station bytes.
- R3: An address whose six bytes are all 8'hFF sets `hit_bcast` and is accepted when `cfg_no_bcast` is 0.
- R4: With `cfg_no_bcast` at 1, `hit_bcast` stays 0 and an all-ones address is refused unless another rule accepts it. Group hashing of other addresses still works.
- R5: A group address has bit 0 of byte 0 set and is not all ones. Its CRC register starts at 32'hFFFFFFFF. Each byte is fed least significant bit first. For each bit b, the register shifts right and is XORed with 32'hEDB88320 when (old bit 0 XOR b) is 1. The value of register bits [31:26], with bit 31 as MSB, indexes `cfg_hash`. `hit_mcast` equals that table bit.
- R6: With `cfg_promisc` at 1, every frame that delivers six address bytes is accepted. The hit flags still report their own rules.
- R7: `dec_valid` is a single-cycle pulse in the cycle after the sixth byte is taken. Outside that cycle, the accept flag and all hit flags are 0.
- R8: If `rx_end` arrives before the sixth byte is taken, no strobe is given for that frame. Later bytes are ignored until the next `rx_sof`.
- R9: Bytes count only in cycles with `rx_valid` high, so idle gaps are allowed. Bytes after the sixth produce no further strobe.
- R10: `rx_sof` restarts address collection and discards any partial address. A byte presented in the same cycle as `rx_sof` is not taken.
- R11: `dec_accept` equals `cfg_promisc` OR `hit_phys` OR `hit_bcast` OR `hit_mcast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Pulse: delimiter seen, the next valid byte is address byte 0 |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_data | input | 8 | Receive byte |
| rx_end | input | 1 | Pulse: frame has ended |
| cfg_station | input | 48 | Station address, byte 0 in bits [7:0] |
| cfg_hash | input | 64 | Group address hash table |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_no_bcast | input | 1 | Refuse the broadcast rule |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| hit_phys | output | 1 | Station address matched |
| hit_bcast | output | 1 | Broadcast rule matched |
| hit_mcast | output | 1 | Hash rule matched |

## Verification
The assertions assume that the configuration inputs stay still from `rx_sof` until the strobe. They also assume that two decisions are always at least seven cycles apart, because each one needs a start pulse and six bytes. The bench changes configuration only between frames, and every frame opens with its own start pulse. The single-cycle-pulse check therefore never sees two adjacent strobes.

// File: rtl/rxaf_pkg.sv
// Package: shared constants and the bit-serial CRC-32 byte update used by the
// group-address hash. Assumes the reflected polynomial and LSB-first bit order.
package rxaf_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    // Advance the CRC register over one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int k = 0; k < BYTE_W; k++) begin
            if (c[0] ^ d[k])
                c = (c >> 1) ^ CRC_POLY;
            else
                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_byte_track.sv
// Byte tracker: counts address bytes after a start pulse and flags the first
// and the last one. Assumes rx_sof has priority over a byte in the same cycle.
module rxaf_byte_track #(
    parameter int unsigned ADDR_BYTES = 6,
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic             rx_end,
    output logic             take,
    output logic [CNT_W-1:0] idx,
    output logic             first_byte,
    output logic             last_byte
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Combinational: a byte is taken only while collecting and not restarting.
    always_comb begin
        take       = active && rx_valid && !rx_sof;
        idx        = cnt;
        first_byte = take && (cnt == '0);
        last_byte  = take && (cnt == LAST_IDX);
    end

    // Collection state: start, count, and stop on last byte or frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (rx_sof) begin
            active <= 1'b1;
            cnt    <= '0;
        end else begin
            if (take)
                cnt <= cnt + 1'b1;
            if (last_byte || rx_end)
                active <= 1'b0;
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(ADDR_BYTES));
    assert_sof_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> (active && cnt == '0));
    assert_end_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !rx_sof) |=> !active);

endmodule

// File: rtl/rxaf_addr_cmp.sv
// Address comparator: accumulates the station-address and all-ones matches
// byte by byte and keeps bit 0 of byte 0. Results include the current byte.
module rxaf_addr_cmp #(
    parameter int unsigned ADDR_BYTES = 6,
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
    localparam int unsigned ADDR_W = ADDR_BYTES * rxaf_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             take,
    input  logic             first_byte,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [ADDR_W-1:0] station,
    output logic             phys_now,
    output logic             bcast_now,
    output logic             group_now
);

    logic       phys_ok;
    logic       bcast_ok;
    logic       group_q;
    logic [7:0] st_byte;

    // Combinational: select the station byte for this position, fold in byte.
    always_comb begin
        st_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (idx == CNT_W'(i))
                st_byte = station[i*8 +: 8];
        phys_now  = phys_ok && (data == st_byte);
        bcast_now = bcast_ok && (data == 8'hFF);
        group_now = first_byte ? data[0] : group_q;
    end

    // Running match state, re-armed by every start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_ok  <= 1'b0;
            bcast_ok <= 1'b0;
            group_q  <= 1'b0;
        end else if (start) begin
            phys_ok  <= 1'b1;
            bcast_ok <= 1'b1;
            group_q  <= 1'b0;
        end else if (take) begin
            phys_ok  <= phys_now;
            bcast_ok <= bcast_now;
            group_q  <= group_now;
        end
    end

    assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phys_ok && bcast_ok));
    assert_bcast_is_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first_byte && bcast_ok) |-> group_q);

endmodule

// File: rtl/rxaf_crc_hash.sv
// Hash generator: runs CRC-32 over the address bytes and exposes the hash
// index that the current byte would produce. Assumes fixed LSB-first order.
module rxaf_crc_hash #(
    parameter int unsigned HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              take,
    input  logic [7:0]        data,
    output logic [HASH_W-1:0] hash_now
);

    import rxaf_pkg::*;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;

    // Combinational: CRC after the current byte; index from its top bits.
    always_comb begin
        crc_nx   = crc_byte(crc_q, data);
        hash_now = crc_nx[CRC_W-1 -: HASH_W];
    end

    // CRC register, preset on start, advanced on each taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= CRC_INIT;
        else if (start)
            crc_q <= CRC_INIT;
        else if (take)
            crc_q <= crc_nx;
    end

    assert_crc_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (crc_q == CRC_INIT));

endmodule

// File: rtl/rxaf_top.sv
// Receive destination address filter: station, broadcast and hashed group
// rules plus promiscuous override; a registered verdict one cycle after the
// last address byte. Assumes configuration is steady during address bytes.
module rxaf_top #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_W     = 6,
    localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1),
    localparam int unsigned ADDR_W    = ADDR_BYTES * 8,
    localparam int unsigned HASH_N    = 1 << HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic [ADDR_W-1:0] cfg_station,
    input  logic [HASH_N-1:0] cfg_hash,
    input  logic              cfg_promisc,
    input  logic              cfg_no_bcast,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              hit_phys,
    output logic              hit_bcast,
    output logic              hit_mcast
);

    logic             take, first_byte, last_byte;
    logic [CNT_W-1:0] idx;
    logic             phys_now, bcast_now, group_now;
    logic [HASH_W-1:0] hash_now;
    logic             d_phys, d_bcast, d_mcast, d_accept;

    rxaf_byte_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_end(rx_end), .take(take), .idx(idx),
        .first_byte(first_byte), .last_byte(last_byte)
    );

    rxaf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .start(rx_sof), .take(take),
        .first_byte(first_byte), .idx(idx), .data(rx_data),
        .station(cfg_station), .phys_now(phys_now),
        .bcast_now(bcast_now), .group_now(group_now)
    );

    rxaf_crc_hash #(.HASH_W(HASH_W)) u_hash (
        .clk(clk), .rst_n(rst_n), .start(rx_sof), .take(take),
        .data(rx_data), .hash_now(hash_now)
    );

    // Combinational: apply the rule controls to the raw matches.
    always_comb begin
        d_phys   = phys_now;
        d_bcast  = bcast_now && !cfg_no_bcast;
        d_mcast  = group_now && !bcast_now && cfg_hash[hash_now];
        d_accept = cfg_promisc || d_phys || d_bcast || d_mcast;
    end

    // Verdict register: loaded on the last byte, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            hit_phys   <= 1'b0;
            hit_bcast  <= 1'b0;
            hit_mcast  <= 1'b0;
        end else begin
            dec_valid  <= last_byte;
            dec_accept <= last_byte && d_accept;
            hit_phys   <= last_byte && d_phys;
            hit_bcast  <= last_byte && d_bcast;
            hit_mcast  <= last_byte && d_mcast;
        end
    end

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_accept || hit_phys || hit_bcast || hit_mcast));
    assert_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ($past(rx_valid) && !$past(rx_sof)));
    assert_hit_accepts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_phys || hit_bcast || hit_mcast) |-> dec_accept);
    assert_bc_mc_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_bcast && hit_mcast));
    assert_no_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && cfg_no_bcast) |=> !hit_bcast);

endmodule

// File: tb/sim_rxaf_top.sv
// Bench: sweeps of station, broadcast, hash and framing cases with a
// reference model computed from the requirement text.
module sim_rxaf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] cfg_station = '0;
    logic [63:0] cfg_hash = '0;
    logic        cfg_promisc = 1'b0, cfg_no_bcast = 1'b0;
    logic        dec_valid, dec_accept, hit_phys, hit_bcast, hit_mcast;

    int checks = 0, fails = 0, n_strobe = 0;
    logic [3:0] cap = '0;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

    always #5 clk = ~clk;

    rxaf_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .cfg_station(cfg_station),
        .cfg_hash(cfg_hash), .cfg_promisc(cfg_promisc),
        .cfg_no_bcast(cfg_no_bcast), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .hit_phys(hit_phys),
        .hit_bcast(hit_bcast), .hit_mcast(hit_mcast)
    );

    // Strobe capture away from the active edge.
    always @(negedge clk) begin
        if (dec_valid) begin
            n_strobe <= n_strobe + 1;
            cap <= {dec_accept, hit_phys, hit_bcast, hit_mcast};
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Hash index per R5, over the 48-bit address as one LSB-first bit stream.
    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[0] ^ a[i];
            r = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r[31:26];
    endfunction

    // Expected {accept, phys, bcast, mcast} per R2..R6, R11.
    function automatic logic [3:0] ref_dec(input logic [47:0] a);
        logic ph, bc, mc;
        ph = (a == cfg_station);
        bc = (a == 48'hFFFF_FFFF_FFFF) && !cfg_no_bcast;
        mc = a[0] && (a != 48'hFFFF_FFFF_FFFF) && cfg_hash[ref_hash(a)];
        return {cfg_promisc | ph | bc | mc, ph, bc, mc};
    endfunction

    function automatic logic [47:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg[63:16];
    endfunction

    // Drive a start pulse and n bytes of address a (byte i = a[8i+7:8i]).
    task automatic frame(input logic [47:0] a, input int n, input int gap,
                         input bit end_after);
        @(negedge clk); rx_sof = 1'b1; rx_valid = 1'b0;
        @(negedge clk); rx_sof = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i > 0)
                for (int g = 0; g < gap; g++) begin
                    rx_valid = 1'b0; @(negedge clk);
                end
            rx_valid = 1'b1; rx_data = a[8*(i%6) +: 8];
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (end_after) begin
            rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
        end
    endtask

    // Full frame then compare the captured verdict with the model.
    task automatic judge(input logic [47:0] a, input int gap, input string req);
        int s0;
        logic [3:0] e;
        s0 = n_strobe;
        e = ref_dec(a);
        frame(a, 6, gap, 1'b0);
        repeat (2) @(negedge clk);
        #1;
        chk(n_strobe == s0 + 1, {req, " strobe"}, 64'(n_strobe - s0), 64'd1);
        chk(cap == e, req, 64'(cap), 64'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] a;
        int s0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({dec_valid, dec_accept, hit_phys, hit_bcast, hit_mcast} == 5'b0,
            "R1 during reset", 64'({dec_valid, dec_accept, hit_phys, hit_bcast, hit_mcast}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dec_valid, dec_accept, hit_phys, hit_bcast, hit_mcast} == 5'b0,
            "R1 after reset", 64'({dec_valid, dec_accept, hit_phys, hit_bcast, hit_mcast}), 0);

        cfg_station = 48'h5A3C_917E_24C8;
        cfg_hash    = 64'h0;

        // R7: strobe lands in the cycle after byte six, for one cycle only
        frame(cfg_station, 6, 0, 1'b0);
        chk(dec_valid && dec_accept && hit_phys, "R7 strobe timing",
            64'({dec_valid, dec_accept, hit_phys}), 64'b111);
        @(negedge clk);
        chk(!dec_valid && !dec_accept && !hit_phys, "R7 strobe width",
            64'({dec_valid, dec_accept, hit_phys}), 0);

        // R2: exact match, each single-bit flip, and reversed byte order
        judge(cfg_station, 0, "R2 exact");
        for (int b = 0; b < 48; b++) judge(cfg_station ^ (48'd1 << b), 0, "R2 flip");
        judge({cfg_station[7:0], cfg_station[15:8], cfg_station[23:16],
               cfg_station[31:24], cfg_station[39:32], cfg_station[47:40]}, 0, "R2 order");

        // R3/R4/R6: broadcast over all control combinations
        for (int m = 0; m < 4; m++) begin
            cfg_no_bcast = m[0]; cfg_promisc = m[1];
            judge(48'hFFFF_FFFF_FFFF, 0, m[0] ? "R4 bcast refused" : "R3 bcast");
        end
        cfg_promisc = 1'b0; cfg_no_bcast = 1'b0;

        // R5/R4: hash table single bit set and single bit cleared
        for (int k = 0; k < 40; k++) begin
            a = next_rand(); a[0] = 1'b1;
            cfg_no_bcast = k[0];
            cfg_hash = 64'd1 << ref_hash(a);
            judge(a, k % 3, "R5 hash hit");
            cfg_hash = ~(64'd1 << ref_hash(a));
            judge(a, 0, "R5 hash miss");
        end
        // R5: unicast address ignores a full table
        cfg_hash = '1;
        for (int k = 0; k < 8; k++) begin
            a = next_rand(); a[0] = 1'b0;
            judge(a, 0, "R5 unicast");
        end
        cfg_hash = 64'h0; cfg_no_bcast = 1'b0;

        // R6/R11: promiscuous accepts random addresses
        cfg_promisc = 1'b1;
        for (int k = 0; k < 8; k++) judge(next_rand(), 1, "R6 promisc");
        judge(cfg_station, 0, "R6 promisc phys");
        cfg_promisc = 1'b0;

        // R11: non-matching address rejected
        judge(48'h0102_0304_0506, 0, "R11 reject");

        // R8: short frame ended early, then stray bytes
        s0 = n_strobe;
        frame(cfg_station, 3, 0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_data = cfg_station[8*i +: 8]; @(negedge clk);
        end
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(n_strobe == s0, "R8 short frame", 64'(n_strobe - s0), 0);

        // R9: bytes after the sixth give no second strobe; gaps tolerated
        s0 = n_strobe;
        frame(cfg_station, 10, 2, 1'b0);
        repeat (4) @(negedge clk);
        #1;
        chk(n_strobe == s0 + 1, "R9 extra bytes", 64'(n_strobe - s0), 1);
        chk(cap == 4'b1100, "R9 verdict", 64'(cap), 64'b1100);
        judge(cfg_station, 3, "R9 gaps");

        // R10: restart mid-address discards the partial bytes
        s0 = n_strobe;
        frame(48'hFFFF_FFFF_FFFF, 3, 0, 1'b0);
        judge(cfg_station, 0, "R10 restart");
        @(negedge clk);
        rx_sof = 1'b1; rx_valid = 1'b1; rx_data = 8'hFF;
        @(negedge clk);
        rx_sof = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rx_data = cfg_station[8*i +: 8]; @(negedge clk);
        end
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(cap == 4'b1100, "R10 sof byte dropped", 64'(cap), 64'b1100);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule